// File: doc/BRIEF.md
# Virtual Interrupt Maintenance Status

This block watches the state of a virtualised interrupt interface and works out which maintenance conditions the hypervisor has asked to hear about. From the per-condition enable bits, the guest's group 0 and group 1 enables, the state fields of a parameterised set of list registers, an end-of-interrupt status vector and an end-of-interrupt count, it derives eight flags. The flags are captured in a register on every clock edge.

The registered flags are presented as a read-only 32-bit status value, with the upper 24 bits held at zero. A single maintenance interrupt line is raised whenever any flag is set. All pins are plain control and status signals. There is no data stream and so no valid/ready handshake: the status value is always current and needs no back-pressure. A synchronous active-high reset clears every flag.

Each list-register state field is 2 bits wide: 0 means invalid, 1 pending, 2 active, and 3 pending and active. The number of list registers is a parameter from 1 to 16.

Top module: `vmnt_status`

## Requirements
- R1: While `rst` is high at a clock edge, the status register is cleared, so `status_word` reads 0 and `maint_irq` is 0 after that edge.
- R2: Bits 31 down to 8 of `status_word` always read 0.
- R3: Bit 0 (end of interrupt) is 1 exactly when at least one bit of `eoi_status` was 1. It has no enable.
- R4: Bit 1 (underflow) is 1 when `en_underflow` is 1 and at most one list register has a non-zero state field.
- R5: Bit 2 (entry not present) is 1 when `en_no_entry` is 1 and `eoi_count` is non-zero.
- R6: Bit 3 (no pending) is 1 when `en_no_pending` is 1 and no list register holds state 1 or state 3. State 2 alone does not count as pending.
- R7: Bit 4 is `en_g0_on` AND `vm_grp0_en`. Bit 5 is `en_g0_off` AND NOT `vm_grp0_en`.
- R8: Bit 6 is `en_g1_on` AND `vm_grp1_en`. Bit 7 is `en_g1_off` AND NOT `vm_grp1_en`.
- R9: `maint_irq` is the OR of `status_word` bits 7 down to 0.
- R10: The flags reflect the inputs sampled at the previous rising clock edge. A change of the inputs between edges leaves `status_word` unchanged until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_underflow | input | 1 | Enable for the underflow flag |
| en_no_entry | input | 1 | Enable for the entry-not-present flag |
| en_no_pending | input | 1 | Enable for the no-pending flag |
| en_g0_on | input | 1 | Enable for the group-0-enabled flag |
| en_g0_off | input | 1 | Enable for the group-0-disabled flag |
| en_g1_on | input | 1 | Enable for the group-1-enabled flag |
| en_g1_off | input | 1 | Enable for the group-1-disabled flag |
| vm_grp0_en | input | 1 | Guest group 0 enable |
| vm_grp1_en | input | 1 | Guest group 1 enable |
| lr_state | input | 2*NUM_LR | List-register state fields; entry i occupies bits 2i+1 down to 2i |
| eoi_status | input | NUM_LR | End-of-interrupt status vector |
| eoi_count | input | EOI_W | End-of-interrupt count |
| status_word | output | 32 | Registered maintenance status |
| maint_irq | output | 1 | Maintenance interrupt line |

## Verification
The hardest corner to reach is the boundary of the underflow flag. The count of valid entries must move across one, and the state codes that make an entry valid must differ from the ones that make it pending. The stimulus therefore steps the list registers through zero, one, two and all-valid occupancy, using each of the three non-zero codes. It places an active-only entry next to pending ones, so that the underflow flag and the no-pending flag separate. For the latency requirement, the inputs are changed between edges and the status is checked before the next edge.

// File: rtl/vmnt_pkg.sv
package vmnt_pkg;
  localparam int FLAG_W     = 8;
  localparam int REG_W      = 32;
  localparam int LR_STATE_W = 2;

  localparam int BIT_EOI    = 0;
  localparam int BIT_UNDER  = 1;
  localparam int BIT_NOENT  = 2;
  localparam int BIT_NOPEND = 3;
  localparam int BIT_G0ON   = 4;
  localparam int BIT_G0OFF  = 5;
  localparam int BIT_G1ON   = 6;
  localparam int BIT_G1OFF  = 7;

  typedef enum logic [LR_STATE_W-1:0] {
    LR_INVALID  = 2'd0,
    LR_PEND     = 2'd1,
    LR_ACT      = 2'd2,
    LR_PEND_ACT = 2'd3
  } lr_state_e;
endpackage

// File: rtl/vmnt_lr_scan.sv
module vmnt_lr_scan
  import vmnt_pkg::*;
#(
  parameter int NUM_LR = 4
) (
  input  logic [NUM_LR*LR_STATE_W-1:0] lr_state,
  output logic                         few_valid,
  output logic                         none_pending
);
  localparam int CNT_W = $clog2(NUM_LR + 1);

  logic [NUM_LR-1:0] valid_v;
  logic [NUM_LR-1:0] pend_v;
  logic [CNT_W-1:0]  valid_cnt;

  for (genvar i = 0; i < NUM_LR; i++) begin : g_entry
    lr_state_e st;
    assign st         = lr_state_e'(lr_state[i*LR_STATE_W +: LR_STATE_W]);
    assign valid_v[i] = (st != LR_INVALID);
    assign pend_v[i]  = (st == LR_PEND) || (st == LR_PEND_ACT);
  end

  always_comb begin
    valid_cnt = '0;
    for (int i = 0; i < NUM_LR; i++) begin
      valid_cnt = valid_cnt + CNT_W'(valid_v[i]);
    end
  end

  assign few_valid    = (valid_cnt <= CNT_W'(1));
  assign none_pending = ~|pend_v;
endmodule

// File: rtl/vmnt_flag_comb.sv
module vmnt_flag_comb
  import vmnt_pkg::*;
#(
  parameter int NUM_LR = 4,
  parameter int EOI_W  = 5
) (
  input  logic              en_underflow,
  input  logic              en_no_entry,
  input  logic              en_no_pending,
  input  logic              en_g0_on,
  input  logic              en_g0_off,
  input  logic              en_g1_on,
  input  logic              en_g1_off,
  input  logic              vm_grp0_en,
  input  logic              vm_grp1_en,
  input  logic              few_valid,
  input  logic              none_pending,
  input  logic [NUM_LR-1:0] eoi_status,
  input  logic [EOI_W-1:0]  eoi_count,
  output logic [FLAG_W-1:0] flags
);
  always_comb begin
    flags             = '0;
    flags[BIT_EOI]    = |eoi_status;
    flags[BIT_UNDER]  = en_underflow  & few_valid;
    flags[BIT_NOENT]  = en_no_entry   & (eoi_count != '0);
    flags[BIT_NOPEND] = en_no_pending & none_pending;
    flags[BIT_G0ON]   = en_g0_on      &  vm_grp0_en;
    flags[BIT_G0OFF]  = en_g0_off     & ~vm_grp0_en;
    flags[BIT_G1ON]   = en_g1_on      &  vm_grp1_en;
    flags[BIT_G1OFF]  = en_g1_off     & ~vm_grp1_en;
  end
endmodule

// File: rtl/vmnt_status.sv
module vmnt_status
  import vmnt_pkg::*;
#(
  parameter int NUM_LR = 4,
  parameter int EOI_W  = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en_underflow,
  input  logic                         en_no_entry,
  input  logic                         en_no_pending,
  input  logic                         en_g0_on,
  input  logic                         en_g0_off,
  input  logic                         en_g1_on,
  input  logic                         en_g1_off,
  input  logic                         vm_grp0_en,
  input  logic                         vm_grp1_en,
  input  logic [NUM_LR*LR_STATE_W-1:0] lr_state,
  input  logic [NUM_LR-1:0]            eoi_status,
  input  logic [EOI_W-1:0]             eoi_count,
  output logic [REG_W-1:0]             status_word,
  output logic                         maint_irq
);
  localparam int PAD_W = REG_W - FLAG_W;

  logic              few_valid;
  logic              none_pending;
  logic [FLAG_W-1:0] flags_d;
  logic [FLAG_W-1:0] status_q;

  vmnt_lr_scan #(.NUM_LR(NUM_LR)) u_scan (
    .lr_state     (lr_state),
    .few_valid    (few_valid),
    .none_pending (none_pending)
  );

  vmnt_flag_comb #(.NUM_LR(NUM_LR), .EOI_W(EOI_W)) u_flags (
    .en_underflow  (en_underflow),
    .en_no_entry   (en_no_entry),
    .en_no_pending (en_no_pending),
    .en_g0_on      (en_g0_on),
    .en_g0_off     (en_g0_off),
    .en_g1_on      (en_g1_on),
    .en_g1_off     (en_g1_off),
    .vm_grp0_en    (vm_grp0_en),
    .vm_grp1_en    (vm_grp1_en),
    .few_valid     (few_valid),
    .none_pending  (none_pending),
    .eoi_status    (eoi_status),
    .eoi_count     (eoi_count),
    .flags         (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= flags_d;
  end

  assign status_word = {{PAD_W{1'b0}}, status_q};
  assign maint_irq   = |status_q;

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    past_ok && $past(rst) |-> status_q == '0); // R1
  AST_EOI_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) |-> status_q[BIT_EOI] == $past(|eoi_status)); // R3
  AST_UNDER_GATED: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && !$past(en_underflow) |-> !status_q[BIT_UNDER]); // R4
  AST_NOENT_ZERO: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && ($past(eoi_count) == '0) |-> !status_q[BIT_NOENT]); // R5
  AST_NOPEND_GATED: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && !$past(en_no_pending) |-> !status_q[BIT_NOPEND]); // R6
  AST_G0_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> !(status_q[BIT_G0ON] && status_q[BIT_G0OFF])); // R7
  AST_G1_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> !(status_q[BIT_G1ON] && status_q[BIT_G1OFF])); // R8
endmodule

// File: tb/vmnt_status_test.sv
module vmnt_status_test;
  localparam int NUM_LR = 4;
  localparam int EOI_W  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_underflow = 0, en_no_entry = 0, en_no_pending = 0;
  logic en_g0_on = 0, en_g0_off = 0, en_g1_on = 0, en_g1_off = 0;
  logic vm_grp0_en = 0, vm_grp1_en = 0;
  logic [2*NUM_LR-1:0] lr_state = '0;
  logic [NUM_LR-1:0]   eoi_status = '0;
  logic [EOI_W-1:0]    eoi_count = '0;
  logic [31:0]         status_word;
  logic                maint_irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vmnt_status #(.NUM_LR(NUM_LR), .EOI_W(EOI_W)) uut (
    .clk(clk), .rst(rst),
    .en_underflow(en_underflow), .en_no_entry(en_no_entry),
    .en_no_pending(en_no_pending), .en_g0_on(en_g0_on), .en_g0_off(en_g0_off),
    .en_g1_on(en_g1_on), .en_g1_off(en_g1_off),
    .vm_grp0_en(vm_grp0_en), .vm_grp1_en(vm_grp1_en),
    .lr_state(lr_state), .eoi_status(eoi_status), .eoi_count(eoi_count),
    .status_word(status_word), .maint_irq(maint_irq)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive at a falling edge, then sample at the falling edge after the next rise
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    en_underflow = 0; en_no_entry = 0; en_no_pending = 0;
    en_g0_on = 0; en_g0_off = 0; en_g1_on = 0; en_g1_off = 0;
    vm_grp0_en = 0; vm_grp1_en = 0;
    lr_state = {NUM_LR{2'd2}}; eoi_status = '0; eoi_count = '0;
  endtask

  task automatic t_reset();
    en_g0_off = 1; eoi_status = 4'b0001; rst = 1;
    step();
    chk("R1 status after reset", status_word, 32'h0);
    chk("R1 irq after reset", {31'b0, maint_irq}, 32'h0);
    rst = 0;
    idle_inputs();
    step();
  endtask

  task automatic t_eoi();
    idle_inputs();
    eoi_status = 4'b1000; step();
    chk("R3 eoi high bit", status_word, 32'h1);
    chk("R9 irq from eoi", {31'b0, maint_irq}, 32'h1);
    eoi_status = 4'b0000; step();
    chk("R3 eoi clear", status_word, 32'h0);
    chk("R9 irq clear", {31'b0, maint_irq}, 32'h0);
  endtask

  task automatic t_underflow();
    idle_inputs();
    en_underflow = 1;
    lr_state = 8'b00_00_00_00; step();
    chk("R4 zero valid", status_word & 32'h2, 32'h2);
    lr_state = 8'b00_10_00_00; step();
    chk("R4 one active valid", status_word & 32'h2, 32'h2);
    lr_state = 8'b00_00_00_11; step();
    chk("R4 one pend-act valid", status_word & 32'h2, 32'h2);
    lr_state = 8'b01_00_10_00; step();
    chk("R4 two valid", status_word & 32'h2, 32'h0);
    lr_state = 8'b11_01_10_01; step();
    chk("R4 all valid", status_word & 32'h2, 32'h0);
    en_underflow = 0; lr_state = 8'b0; step();
    chk("R4 disabled", status_word, 32'h0);
  endtask

  task automatic t_noentry();
    idle_inputs();
    en_no_entry = 1; eoi_count = 5'd0; step();
    chk("R5 count zero", status_word, 32'h0);
    eoi_count = 5'd31; step();
    chk("R5 count max", status_word, 32'h4);
    eoi_count = 5'd1; step();
    chk("R5 count one", status_word, 32'h4);
    en_no_entry = 0; step();
    chk("R5 disabled", status_word, 32'h0);
  endtask

  task automatic t_nopend();
    idle_inputs();
    en_no_pending = 1;
    lr_state = 8'b10_10_10_10; step();
    chk("R6 all active only", status_word, 32'h8);
    lr_state = 8'b10_11_10_10; step();
    chk("R6 pend-act present", status_word, 32'h0);
    lr_state = 8'b00_00_00_01; step();
    chk("R6 pend present", status_word & 32'h8, 32'h0);
    lr_state = 8'b0; step();
    chk("R6 all invalid", status_word & 32'h8, 32'h8);
    en_no_pending = 0; lr_state = 8'b10_10_10_10; step();
    chk("R6 disabled", status_word, 32'h0);
  endtask

  task automatic t_groups();
    idle_inputs();
    en_g0_on = 1; en_g0_off = 1; en_g1_on = 1; en_g1_off = 1;
    vm_grp0_en = 1; vm_grp1_en = 0; step();
    chk("R7 R8 g0 on g1 off", status_word, 32'h90);
    vm_grp0_en = 0; vm_grp1_en = 1; step();
    chk("R7 R8 g0 off g1 on", status_word, 32'h60);
    en_g0_off = 0; en_g1_on = 0; step();
    chk("R7 R8 enables low", status_word, 32'h0);
    chk("R9 irq idle", {31'b0, maint_irq}, 32'h0);
  endtask

  task automatic t_all_and_latency();
    idle_inputs();
    en_underflow = 1; en_no_entry = 1; en_no_pending = 1;
    en_g0_on = 1; en_g1_off = 1; vm_grp0_en = 1;
    lr_state = 8'b0; eoi_status = 4'b0100; eoi_count = 5'd3; step();
    chk("R2 R9 all set", status_word, 32'h9F);
    chk("R9 irq all", {31'b0, maint_irq}, 32'h1);
    idle_inputs();
    #1;
    chk("R10 holds before edge", status_word, 32'h9F);
    step();
    chk("R10 updates after edge", status_word, 32'h0);
    chk("R2 upper zero", status_word & 32'hFFFF_FF00, 32'h0);
  endtask

  initial begin
    idle_inputs();
    @(negedge clk);
    t_reset();
    t_eoi();
    t_underflow();
    t_noentry();
    t_nopend();
    t_groups();
    t_all_and_latency();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog got=%h exp=%h", 0, 1);
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule